// File: doc/BRIEF.md
# Guest Bus Mailbox Bridge

This block gives a 32-bit host register bus indirect access to a set of small 8-bit peripherals ("guests") that sit on a local guest bus. It has one mailbox word. A single host write to that word loads four things: a transfer direction, a guest number, a register index inside that guest, and a data byte. The write then starts exactly one guest-bus transfer. The guest bus uses a strobe and acknowledge handshake. The guest select, register index, direction and write byte stay constant for the whole time the strobe is high.

While a transfer is in flight, the mailbox reports it as pending, and any further mailbox write is dropped. A transfer ends in one of two ways: the guest acknowledges, or the bridge gives up. The bridge gives up at once when the guest slot is unpopulated, or after a fixed number of cycles with no acknowledge. Giving up sets a sticky timeout flag, which software clears by writing a one to that bit. A host read of the mailbox returns the status bits, the fields last loaded, and the byte last returned by a guest read.

Two further host registers hold a 4-bit timing field for each guest. Each of their byte lanes can be written on its own. The guest count, the timeout length and the map of populated guest slots are parameters. The reduced variant uses 4 guests and a 32-cycle timeout.

Top module: `gbm_bridge`

## Requirements
- R1: After reset the mailbox reads 0x0080_0000: pending (bit 25) is 0, timeout (bit 24) is 0, direction (bit 23) is 1 (write), guest number (bits 22:20) is 0, register index (bits 18:16) is 0 and the returned byte (bits 7:0) is 0. Both timing registers read 0 and the strobe is low.
- R2: A mailbox write with bit 23 = 1 to a populated guest raises `gb_stb_o` from the next cycle, with `gb_we_o` = 1, `gb_sel_o` = bits 22:20, `gb_reg_o` = bits 18:16 and `gb_wdata_o` = bits 7:0 of the written word. These stay constant until the acknowledge.
- R3: A mailbox write with bit 23 = 0 performs a guest read. At the acknowledge edge the byte on `gb_rdata_i` is captured, and it is returned in mailbox bits 7:0 from then on. Write transfers leave that byte unchanged.
- R4: Pending (bit 25) reads 1 from the cycle after an accepted mailbox write until the edge at which the guest acknowledges, and 0 after that.
- R5: A mailbox write that arrives while pending is 1 has no effect. The fields, the timeout flag and the running transfer are unchanged, and no second transfer follows.
- R6: A transfer to a guest number that is not populated, or that is at or above NUM_GUESTS, never raises the strobe. It sets timeout and clears pending at the first edge after the accepting write.
- R7: If a populated guest does not acknowledge, the strobe stays high for exactly TIMEOUT_CYC cycles (default 64). At the TIMEOUT_CYC-th edge after the accepting write, the strobe drops, pending clears and timeout is set.
- R8: The timeout flag is sticky. An accepted mailbox write with bit 24 = 0 leaves it set. An accepted mailbox write with bit 24 = 1 clears it.
- R9: Host address 1 holds the timing fields of guests 0 to 3, and host address 2 holds those of guests 4 to 7. Guest n of a bank sits at bits 4n+3:4n. Byte lane 0 (bits 7:0) is written only when `host_be_i[0]` is set, and byte lane 1 (bits 15:8) only when `host_be_i[1]` is set. Bits 31:16 read 0.
- R10: Mailbox bits 31:26, 19 and 15:8 always read 0, and writing bit 25 has no effect on pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_req_i | input | 1 | Host access request |
| host_we_i | input | 1 | Host write enable |
| host_addr_i | input | 2 | Register select: 0 mailbox, 1 timing bank 0, 2 timing bank 1 |
| host_be_i | input | 4 | Host byte enables |
| host_wdata_i | input | 32 | Host write data |
| host_rdata_o | output | 32 | Read data for the register selected by host_addr_i |
| gb_stb_o | output | 1 | Guest bus transfer strobe |
| gb_we_o | output | 1 | Guest bus direction, 1 = write to guest |
| gb_sel_o | output | 3 | Guest select |
| gb_reg_o | output | 3 | Guest register index |
| gb_wdata_o | output | 8 | Byte written to the guest |
| gb_rdata_i | input | 8 | Byte returned by the guest |
| gb_ack_i | input | 1 | Guest acknowledge |

## Verification
The hardest conditions to reach are the exact boundary of the timeout window and a mailbox write that lands while a transfer is still open. To reach both, the bench guest model has a programmable acknowledge delay and a mute switch. Muting the guest holds the strobe open, so the bench can sample one cycle before and one cycle after the TIMEOUT_CYC-th edge. A long acknowledge delay leaves room for a second mailbox write mid-transfer, and its absence of effect is read back through the mailbox and the guest's own register contents.

// File: rtl/gbm_pkg.sv
package gbm_pkg;
  localparam int unsigned HOST_AW    = 2;
  localparam int unsigned GID_W      = 3;
  localparam int unsigned GREG_W     = 3;
  localparam int unsigned GDATA_W    = 8;
  localparam int unsigned TIME_W     = 4;
  localparam int unsigned MAX_GUESTS = 8;

  localparam int unsigned MBX_PEND_BIT = 25;
  localparam int unsigned MBX_TO_BIT   = 24;
  localparam int unsigned MBX_DIR_BIT  = 23;
  localparam int unsigned MBX_GID_LSB  = 20;
  localparam int unsigned MBX_GREG_LSB = 16;

  localparam logic [HOST_AW-1:0] ADDR_MBOX  = 2'd0;
  localparam logic [HOST_AW-1:0] ADDR_TBANK0 = 2'd1;
  localparam logic [HOST_AW-1:0] ADDR_TBANK1 = 2'd2;

  typedef enum logic {
    XF_IDLE = 1'b0,
    XF_BUSY = 1'b1
  } xf_state_e;

  typedef struct packed {
    logic              dir;
    logic [GID_W-1:0]  gid;
    logic [GREG_W-1:0] greg;
    logic [GDATA_W-1:0] data;
  } mbx_fields_t;
endpackage

// File: rtl/gbm_timing_regs.sv
module gbm_timing_regs
  import gbm_pkg::*;
#(
  parameter int unsigned NUM_GUESTS = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_bank0_i,
  input  logic        wr_bank1_i,
  input  logic [1:0]  be_i,
  input  logic [15:0] wdata_i,
  output logic [15:0] bank0_o,
  output logic [15:0] bank1_o
);
  localparam int unsigned PER_BANK = 4;

  logic [TIME_W-1:0] fld [MAX_GUESTS];

  for (genvar g = 0; g < MAX_GUESTS; g++) begin : g_fld
    localparam int unsigned BANK = g / PER_BANK;
    localparam int unsigned SLOT = g % PER_BANK;
    localparam int unsigned LANE = SLOT / 2;
    if (g < NUM_GUESTS) begin : g_impl
      logic wr_w;
      assign wr_w = (BANK == 0) ? wr_bank0_i : wr_bank1_i;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) fld[g] <= '0;
        else if (wr_w && be_i[LANE]) fld[g] <= wdata_i[SLOT*TIME_W +: TIME_W];
      end
    end else begin : g_tie
      assign fld[g] = '0;
    end
  end

  assign bank0_o = {fld[3], fld[2], fld[1], fld[0]};
  assign bank1_o = {fld[7], fld[6], fld[5], fld[4]};
endmodule

// File: rtl/gbm_mbx_regs.sv
module gbm_mbx_regs
  import gbm_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [31:0]        wdata_i,
  input  logic               pending_i,
  input  logic               done_ack_i,
  input  logic               done_to_i,
  input  logic [GDATA_W-1:0] gb_rdata_i,
  output logic               start_o,
  output mbx_fields_t        fields_o,
  output logic               timeout_o,
  output logic [GDATA_W-1:0] rbyte_o
);
  mbx_fields_t fields_q;
  logic        to_q;
  logic [GDATA_W-1:0] rbyte_q;

  // writes during an open transfer are dropped whole
  assign start_o = wr_i && !pending_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fields_q <= '{dir: 1'b1, gid: '0, greg: '0, data: '0};
      to_q     <= 1'b0;
      rbyte_q  <= '0;
    end else begin
      if (start_o) begin
        fields_q.dir  <= wdata_i[MBX_DIR_BIT];
        fields_q.gid  <= wdata_i[MBX_GID_LSB +: GID_W];
        fields_q.greg <= wdata_i[MBX_GREG_LSB +: GREG_W];
        fields_q.data <= wdata_i[GDATA_W-1:0];
        if (wdata_i[MBX_TO_BIT]) to_q <= 1'b0;
      end
      if (done_to_i) to_q <= 1'b1;
      if (done_ack_i && !fields_q.dir) rbyte_q <= gb_rdata_i;
    end
  end

  assign fields_o  = fields_q;
  assign timeout_o = to_q;
  assign rbyte_o   = rbyte_q;
endmodule

// File: rtl/gbm_xfer_fsm.sv
module gbm_xfer_fsm
  import gbm_pkg::*;
#(
  parameter int unsigned     NUM_GUESTS    = 8,
  parameter int unsigned     TIMEOUT_CYC   = 64,
  parameter logic [7:0]      GUEST_PRESENT = 8'h03
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [GID_W-1:0] gid_i,
  input  logic             ack_i,
  output logic             pending_o,
  output logic             stb_o,
  output logic             done_ack_o,
  output logic             done_to_o
);
  localparam int unsigned CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYC - 1);

  xf_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             present_w;
  logic             busy_w;

  assign present_w  = (32'(gid_i) < NUM_GUESTS) && GUEST_PRESENT[gid_i];
  assign busy_w     = (state_q == XF_BUSY);
  assign stb_o      = busy_w && present_w;
  assign done_ack_o = stb_o && ack_i;
  // an unpopulated slot gives up at once; a silent guest after the window
  assign done_to_o  = busy_w && (!present_w || (!ack_i && cnt_q == CNT_LAST));
  assign pending_o  = busy_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= XF_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        XF_IDLE: if (start_i) begin
          state_q <= XF_BUSY;
          cnt_q   <= '0;
        end
        XF_BUSY: if (done_ack_o || done_to_o) begin
          state_q <= XF_IDLE;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        default: state_q <= XF_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/gbm_bridge.sv
module gbm_bridge
  import gbm_pkg::*;
#(
  parameter int unsigned NUM_GUESTS    = 8,
  parameter int unsigned TIMEOUT_CYC   = 64,
  parameter logic [7:0]  GUEST_PRESENT = 8'h03
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         host_req_i,
  input  logic         host_we_i,
  input  logic [1:0]   host_addr_i,
  input  logic [3:0]   host_be_i,
  input  logic [31:0]  host_wdata_i,
  output logic [31:0]  host_rdata_o,
  output logic         gb_stb_o,
  output logic         gb_we_o,
  output logic [2:0]   gb_sel_o,
  output logic [2:0]   gb_reg_o,
  output logic [7:0]   gb_wdata_o,
  input  logic [7:0]   gb_rdata_i,
  input  logic         gb_ack_i
);
  logic        wr_w;
  logic        mbx_wr_w;
  logic        start_w;
  logic        pending_w;
  logic        timeout_w;
  logic        done_ack_w;
  logic        done_to_w;
  mbx_fields_t fields_w;
  logic [7:0]  rbyte_w;
  logic [15:0] bank0_w;
  logic [15:0] bank1_w;
  logic [31:0] mbx_word_w;
  logic        unused_be_w;

  assign unused_be_w = ^host_be_i[3:2];
  assign wr_w     = host_req_i && host_we_i;
  assign mbx_wr_w = wr_w && (host_addr_i == ADDR_MBOX);

  gbm_mbx_regs u_mbx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (mbx_wr_w),
    .wdata_i    (host_wdata_i),
    .pending_i  (pending_w),
    .done_ack_i (done_ack_w),
    .done_to_i  (done_to_w),
    .gb_rdata_i (gb_rdata_i),
    .start_o    (start_w),
    .fields_o   (fields_w),
    .timeout_o  (timeout_w),
    .rbyte_o    (rbyte_w)
  );

  gbm_xfer_fsm #(
    .NUM_GUESTS    (NUM_GUESTS),
    .TIMEOUT_CYC   (TIMEOUT_CYC),
    .GUEST_PRESENT (GUEST_PRESENT)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_w),
    .gid_i      (fields_w.gid),
    .ack_i      (gb_ack_i),
    .pending_o  (pending_w),
    .stb_o      (gb_stb_o),
    .done_ack_o (done_ack_w),
    .done_to_o  (done_to_w)
  );

  gbm_timing_regs #(
    .NUM_GUESTS (NUM_GUESTS)
  ) u_time (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_bank0_i (wr_w && (host_addr_i == ADDR_TBANK0)),
    .wr_bank1_i (wr_w && (host_addr_i == ADDR_TBANK1)),
    .be_i       (host_be_i[1:0]),
    .wdata_i    (host_wdata_i[15:0]),
    .bank0_o    (bank0_w),
    .bank1_o    (bank1_w)
  );

  always_comb begin
    mbx_word_w = '0;
    mbx_word_w[MBX_PEND_BIT] = pending_w;
    mbx_word_w[MBX_TO_BIT]   = timeout_w;
    mbx_word_w[MBX_DIR_BIT]  = fields_w.dir;
    mbx_word_w[MBX_GID_LSB  +: GID_W]  = fields_w.gid;
    mbx_word_w[MBX_GREG_LSB +: GREG_W] = fields_w.greg;
    mbx_word_w[GDATA_W-1:0] = rbyte_w;
  end

  always_comb begin
    unique case (host_addr_i)
      ADDR_MBOX:   host_rdata_o = mbx_word_w;
      ADDR_TBANK0: host_rdata_o = {16'h0000, bank0_w};
      ADDR_TBANK1: host_rdata_o = {16'h0000, bank1_w};
      default:     host_rdata_o = '0;
    endcase
  end

  assign gb_we_o    = fields_w.dir;
  assign gb_sel_o   = fields_w.gid;
  assign gb_reg_o   = fields_w.greg;
  assign gb_wdata_o = fields_w.data;
endmodule

// File: rtl/gbm_checker.sv
module gbm_checker #(
  parameter int unsigned NUM_GUESTS    = 8,
  parameter int unsigned TIMEOUT_CYC   = 64,
  parameter logic [7:0]  GUEST_PRESENT = 8'h03
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       mbx_wr_i,
  input logic       clr_to_i,
  input logic       pending_i,
  input logic       timeout_i,
  input logic       gb_stb_i,
  input logic       gb_ack_i,
  input logic       gb_we_i,
  input logic [2:0] gb_sel_i,
  input logic [2:0] gb_reg_i,
  input logic [7:0] gb_wdata_i
);
  localparam int unsigned RUN_W = $clog2(TIMEOUT_CYC + 2);
  logic [RUN_W-1:0] stb_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stb_run_q <= '0;
    else if (gb_stb_i) stb_run_q <= stb_run_q + 1'b1;
    else stb_run_q <= '0;
  end

  a_r4_stb_only_when_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gb_stb_i |-> pending_i);

  a_r4_ack_ends_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gb_stb_i && gb_ack_i) |=> !pending_i);

  a_r2_fields_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gb_stb_i && !gb_ack_i) |=> ($stable(gb_sel_i) && $stable(gb_reg_i) &&
                                 $stable(gb_we_i) && $stable(gb_wdata_i)));

  a_r5_busy_write_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_i && mbx_wr_i) |=> ($stable(gb_sel_i) && $stable(gb_reg_i) && $stable(gb_we_i)));

  a_r6_no_stb_unpopulated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gb_stb_i |-> ((32'(gb_sel_i) < NUM_GUESTS) && GUEST_PRESENT[gb_sel_i]));

  a_r7_window_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(stb_run_q) <= TIMEOUT_CYC);

  a_r8_timeout_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timeout_i && !(mbx_wr_i && !pending_i && clr_to_i)) |=> timeout_i);
endmodule

bind gbm_bridge gbm_checker #(
  .NUM_GUESTS    (NUM_GUESTS),
  .TIMEOUT_CYC   (TIMEOUT_CYC),
  .GUEST_PRESENT (GUEST_PRESENT)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mbx_wr_i   (mbx_wr_w),
  .clr_to_i   (host_wdata_i[24]),
  .pending_i  (pending_w),
  .timeout_i  (timeout_w),
  .gb_stb_i   (gb_stb_o),
  .gb_ack_i   (gb_ack_i),
  .gb_we_i    (gb_we_o),
  .gb_sel_i   (gb_sel_o),
  .gb_reg_i   (gb_reg_o),
  .gb_wdata_i (gb_wdata_o)
);

// File: tb/gbm_bridge_tb.sv
`timescale 1ns/1ps
module gbm_bridge_tb;
  localparam int unsigned TO_CYC = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [3:0]  be = 4'h0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        stb, gwe, ack = 1'b0;
  logic [2:0]  sel, greg;
  logic [7:0]  gwd, grd;

  int errors = 0, checks = 0;
  bit done = 0;

  logic [7:0] gmem [2][8];
  int  ack_dly = 0;
  bit  mute = 0;
  int  wait_cnt = 0;
  logic [7:0] last_rb = 8'h00;

  always #10 clk = ~clk;

  gbm_bridge #(.NUM_GUESTS(8), .TIMEOUT_CYC(TO_CYC), .GUEST_PRESENT(8'h03)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .host_req_i(req), .host_we_i(we), .host_addr_i(addr),
    .host_be_i(be), .host_wdata_i(wdata), .host_rdata_o(rdata), .gb_stb_o(stb),
    .gb_we_o(gwe), .gb_sel_o(sel), .gb_reg_o(greg), .gb_wdata_o(gwd),
    .gb_rdata_i(grd), .gb_ack_i(ack));

  assign grd = gmem[sel[0]][greg];

  // guest model: acknowledges after ack_dly strobe cycles unless muted
  always @(negedge clk) begin
    if (ack) begin
      ack = 1'b0;
      wait_cnt = 0;
    end else if (!stb) begin
      wait_cnt = 0;
    end else if (!mute) begin
      if (wait_cnt >= ack_dly) begin
        ack = 1'b1;
        if (gwe) gmem[sel[0]][greg] = gwd;
      end else wait_cnt++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic host_wr(input logic [1:0] a, input logic [31:0] d, input logic [3:0] b);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d; be = b;
    @(negedge clk);
    req = 1'b0; we = 1'b0; wdata = '0; be = 4'h0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic host_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    peek(a, d);
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 200; i++) begin
      host_rd(2'd0, v);
      if (!v[25]) return;
    end
  endtask

  function automatic logic [31:0] mword(input bit p, input bit t, input bit d,
                                        input int g, input int r, input logic [7:0] b);
    return (32'(p) << 25) | (32'(t) << 24) | (32'(d) << 23) | (32'(g) << 20) |
           (32'(r) << 16) | 32'(b);
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    host_rd(2'd0, v); chk("R1 mailbox reset", v, 32'h0080_0000);
    host_rd(2'd1, v); chk("R1 timing bank0 reset", v, 32'h0);
    host_rd(2'd2, v); chk("R1 timing bank1 reset", v, 32'h0);
    chk("R1 strobe low", {31'b0, stb}, 32'h0);
  endtask

  task automatic t_write();
    logic [31:0] v;
    ack_dly = 3;
    // reserved bits and bit 25 set on purpose (R10)
    host_wr(2'd0, 32'hFE08_FF00 | mword(0, 0, 1, 1, 5, 8'hA5), 4'hF);
    peek(2'd0, v);
    chk("R4 pending after accept", v, mword(1, 0, 1, 1, 5, last_rb));
    chk("R2 strobe", {31'b0, stb}, 32'h1);
    chk("R2 guest bus fields", {16'b0, gwe, sel, greg, gwd}, {16'b0, 1'b1, 3'd1, 3'd5, 8'hA5});
    wait_idle();
    chk("R2 guest stored byte", {24'b0, gmem[1][5]}, 32'hA5);
    host_rd(2'd0, v);
    chk("R10 readback layout", v, mword(0, 0, 1, 1, 5, last_rb));
  endtask

  task automatic t_read();
    logic [31:0] v;
    gmem[0][3] = 8'h3C;
    ack_dly = 1;
    host_wr(2'd0, mword(0, 0, 0, 0, 3, 8'hEE), 4'hF);
    wait_idle();
    last_rb = 8'h3C;
    host_rd(2'd0, v);
    chk("R3 read guest0 reg3", v, mword(0, 0, 0, 0, 3, 8'h3C));
    ack_dly = 0;
    host_wr(2'd0, mword(0, 0, 0, 1, 5, 8'h00), 4'hF);
    wait_idle();
    last_rb = 8'hA5;
    host_rd(2'd0, v);
    chk("R3 read guest1 reg5", v, mword(0, 0, 0, 1, 5, 8'hA5));
  endtask

  task automatic t_busy_ignore();
    logic [31:0] v;
    logic [7:0] keep;
    keep = gmem[0][7];
    ack_dly = 10;
    host_wr(2'd0, mword(0, 0, 1, 1, 2, 8'h11), 4'hF);
    host_wr(2'd0, mword(0, 1, 0, 0, 7, 8'h99), 4'hF);
    chk("R5 fields kept while busy", {24'b0, gwe, sel, greg, 1'b0}, {24'b0, 1'b1, 3'd1, 3'd2, 1'b0});
    wait_idle();
    chk("R5 first transfer completed", {24'b0, gmem[1][2]}, 32'h11);
    chk("R5 dropped target untouched", {24'b0, gmem[0][7]}, {24'b0, keep});
    repeat (3) @(negedge clk);
    chk("R5 no second transfer", {31'b0, stb}, 32'h0);
    peek(2'd0, v);
    chk("R5 mailbox keeps first fields", v, mword(0, 0, 1, 1, 2, last_rb));
  endtask

  task automatic t_unpop();
    logic [31:0] v;
    host_wr(2'd0, mword(0, 0, 1, 5, 1, 8'h42), 4'hF);
    peek(2'd0, v);
    chk("R6 pending in first cycle", {31'b0, v[25]}, 32'h1);
    chk("R6 no strobe to empty slot", {31'b0, stb}, 32'h0);
    host_rd(2'd0, v);
    chk("R6 timeout set next edge", v, mword(0, 1, 1, 5, 1, last_rb));
  endtask

  task automatic t_sticky();
    logic [31:0] v;
    ack_dly = 0;
    host_wr(2'd0, mword(0, 0, 0, 0, 3, 8'h00), 4'hF);
    wait_idle();
    host_rd(2'd0, v);
    chk("R8 timeout kept with bit24=0", v, mword(0, 1, 0, 0, 3, 8'h3C));
    last_rb = 8'h3C;
    host_wr(2'd0, mword(0, 1, 0, 0, 3, 8'h00), 4'hF);
    wait_idle();
    host_rd(2'd0, v);
    chk("R8 timeout cleared with bit24=1", v, mword(0, 0, 0, 0, 3, 8'h3C));
  endtask

  task automatic t_timeout();
    logic [31:0] v;
    mute = 1;
    host_wr(2'd0, mword(0, 0, 1, 1, 0, 8'h77), 4'hF);
    repeat (TO_CYC - 1) @(negedge clk);
    peek(2'd0, v);
    chk("R7 still waiting one cycle early", {30'b0, v[25:24]}, 32'h2);
    chk("R7 strobe held", {31'b0, stb}, 32'h1);
    @(negedge clk);
    peek(2'd0, v);
    chk("R7 timeout at window end", {30'b0, v[25:24]}, 32'h1);
    chk("R7 strobe dropped", {31'b0, stb}, 32'h0);
    mute = 0;
  endtask

  task automatic t_timing();
    logic [31:0] v;
    host_wr(2'd1, 32'h0000_BA98, 4'b0001);
    host_rd(2'd1, v); chk("R9 lane0 only", v, 32'h0000_0098);
    host_wr(2'd1, 32'h0000_7654, 4'b0010);
    host_rd(2'd1, v); chk("R9 lane1 only", v, 32'h0000_7698);
    host_wr(2'd2, 32'hFEDC_3210, 4'b1111);
    host_rd(2'd2, v); chk("R9 bank1 upper bits zero", v, 32'h0000_3210);
    host_rd(2'd1, v); chk("R9 bank0 unaffected", v, 32'h0000_7698);
  endtask

  initial begin
    gmem[0] = '{default: 8'h00};
    gmem[1] = '{default: 8'h00};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write();
    t_read();
    t_busy_ignore();
    t_unpop();
    t_sticky();
    t_timeout();
    t_timing();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule